// File: doc/BRIEF.md
# Serial Port DMA Transfer Controller

This block sits between a byte-wide serial transmitter/receiver pair and a shared memory port. It moves bytes without processor help. It has two independent channels. The receive channel writes each byte the receiver delivers into memory. The transmit channel reads bytes from memory and hands them to the transmit buffer. Software arms each channel with a byte pointer, a byte count and an enable bit. When a block is finished, the channel disarms itself and raises a sticky end-of-block flag, which drives an interrupt. While a channel is armed, its per-byte interrupt is held off.

Transmit needs a software kick. Software writes the first byte straight into the transmit buffer, so DMA fetches begin at the loaded pointer, which holds the second byte. Every later fetch waits for a shifter-empty event, and only while the trigger-source bit selects that event. Receive stops on a line or overrun error and stays stopped until software recovers it. In character-search mode, a byte equal to the compare character is dropped from the stream.

Data moves through two valid/ready streams. On the receiver side, the receiver holds `rx_valid` and `rx_data` while `rx_ready` is low. `rx_ready` is low while the channel holds a byte that has not been written yet, or while the channel is halted or an error flag is set. On the transmit side, the block holds `txb_valid` and `txb_data` until `txb_ready`. Memory uses a request/acknowledge handshake. A request stays asserted with stable address, direction and data until `mem_ack` is high in the same cycle. `mem_rdata` is valid with `mem_ack`.

Top module: `sdma_ctrl`

## Requirements
- R1: Software writes use `cfg_sel`: 0 rx pointer, 1 rx count, 2 tx pointer, 3 tx count, 4 control, 5 compare character (low 8 bits), 6 pending clear. The control word has bit 0 rx enable, bit 1 tx enable, bit 2 trigger source (1 blocks transmit fetches), bit 3 character search. Pointer and count writes to an enabled channel are ignored. An enable write takes effect only when that channel's count is nonzero.
- R2: Each byte the receive channel accepts is written to memory at the rx pointer. The pointer then steps by one modulo 2^AW and the count drops by one.
- R3: When the last byte of a block is moved, the channel's enable clears and its end-of-block flag (`irq_rx_eob` or `irq_tx_eob`) sets. Writing 1 to bit 0 (rx) or bit 1 (tx) of the pending-clear register clears the flag.
- R4: `irq_rx_byte` pulses for a received byte only while rx is disabled. `irq_tx_empty` pulses for a shifter-empty event only while tx is disabled.
- R5: An enabled transmit channel makes no memory read until `cpu_txbuf_wr` pulses. Its first fetch reads the loaded tx pointer.
- R6: After the start, each transmit fetch needs one `tx_empty` pulse while the trigger-source bit is 0. With the bit at 1, no fetch occurs.
- R7: An error flag seen while rx is enabled halts the receive channel (`rx_halt`, `rx_ready` low) until all error flags are low.
- R8: After an overrun halt, the channel resumes only once `rxbuf_rd` has also pulsed.
- R9: With search enabled, a received byte equal to the compare character is accepted but not written. The pointer and count stay unchanged for it.
- R10: A memory request holds address, direction and data until acknowledged. When both channels first request in the same cycle, receive is served first.
- R11: `txb_data` is held stable while `txb_valid` is high and `txb_ready` is low. Every fetched byte reaches the transmit buffer in order.
- R12: While the receive channel holds an unwritten byte, `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Channel accepts received byte |
| rx_err_line | input | 1 | Framing/parity error flag |
| rx_err_ovr | input | 1 | Overrun error flag |
| rxbuf_rd | input | 1 | Software read of receive buffer |
| cpu_txbuf_wr | input | 1 | Software write of transmit buffer |
| tx_empty | input | 1 | Shifter-empty event pulse |
| txb_valid | output | 1 | Byte for transmit buffer valid |
| txb_data | output | 8 | Byte for transmit buffer |
| txb_ready | input | 1 | Transmit buffer accepts byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| irq_rx_byte | output | 1 | Per-byte receive interrupt |
| irq_tx_empty | output | 1 | Per-byte transmit interrupt |
| irq_rx_eob | output | 1 | Receive end-of-block pending |
| irq_tx_eob | output | 1 | Transmit end-of-block pending |
| rx_on | output | 1 | Receive channel enabled |
| tx_on | output | 1 | Transmit channel enabled |
| rx_halt | output | 1 | Receive halted by error |
| rx_ptr | output | AW | Receive pointer |
| rx_cnt | output | CW | Receive count |
| tx_ptr | output | AW | Transmit pointer |
| tx_cnt | output | CW | Transmit count |

## Verification
The bench builds the block with AW = 8 and CW = 4. The 8-bit pointer lets a five-byte receive block starting at 0xFC wrap through 0xFF to 0x00. The 4-bit count keeps every block short enough to walk to end-of-block several times. Memory acknowledges and transmit-buffer readiness are drawn at random, so the hold rules of both handshakes are exercised under stalls. Directed cases cover the start-before-kick, source-select blocking, both error recoveries and a same-cycle request collision.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_RX_PTR = 3'd0,
    SEL_RX_CNT = 3'd1,
    SEL_TX_PTR = 3'd2,
    SEL_TX_CNT = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_MATCH  = 3'd5,
    SEL_PEND   = 3'd6
  } cfg_sel_e;

  localparam int CTRL_RX_EN  = 0;
  localparam int CTRL_TX_EN  = 1;
  localparam int CTRL_SRC    = 2;
  localparam int CTRL_SEARCH = 3;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_WAIT,
    TX_FETCH,
    TX_PUSH
  } tx_st_e;
endpackage

// File: rtl/sdma_rx_chan.sv
module sdma_rx_chan
  import sdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ptr,
  input  logic              ld_cnt,
  input  logic [AW-1:0]     ld_val,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              eob_clr,
  input  logic              search_en,
  input  logic [BYTE_W-1:0] match_char,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              err_line,
  input  logic              err_ovr,
  input  logic              buf_rd,
  output logic              req,
  output logic [BYTE_W-1:0] wdata,
  input  logic              ack,
  output logic [AW-1:0]     ptr,
  output logic [CW-1:0]     cnt,
  output logic              en,
  output logic              eob,
  output logic              halt,
  output logic              byte_irq
);
  logic              hold_v;
  logic [BYTE_W-1:0] hold_d;
  logic              need_rd, rd_seen;
  logic              err_any, take, is_match, last;

  assign err_any  = err_line | err_ovr;
  assign rx_ready = !en || (!halt && !hold_v && !err_any);
  assign take     = rx_valid && rx_ready;
  assign is_match = search_en && (rx_data == match_char);
  assign last     = (cnt == CW'(1));
  assign req      = hold_v;
  assign wdata    = hold_d;
  assign byte_irq = take && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      hold_d  <= '0;
      ptr     <= '0;
      cnt     <= '0;
      en      <= 1'b0;
      eob     <= 1'b0;
      halt    <= 1'b0;
      need_rd <= 1'b0;
      rd_seen <= 1'b0;
    end else begin
      if (ack) begin
        hold_v <= 1'b0;
        ptr    <= ptr + AW'(1);
        cnt    <= cnt - CW'(1);
      end else begin
        if (ld_ptr && !en) ptr <= ld_val;
        if (ld_cnt && !en) cnt <= ld_val[CW-1:0];
      end
      if (take && en && !is_match) begin
        hold_v <= 1'b1;
        hold_d <= rx_data;
      end
      if (ack && last)  en <= 1'b0;
      else if (en_wr)   en <= en_val && (cnt != '0);
      if (ack && last)  eob <= 1'b1;
      else if (eob_clr) eob <= 1'b0;
      if (!halt) begin
        if (en && err_any) begin
          halt    <= 1'b1;
          need_rd <= err_ovr;
          rd_seen <= 1'b0;
        end
      end else if (!err_any && (!need_rd || rd_seen || buf_rd)) begin
        halt    <= 1'b0;
        need_rd <= 1'b0;
        rd_seen <= 1'b0;
      end else begin
        if (err_ovr) need_rd <= 1'b1;
        if (buf_rd)  rd_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdma_tx_chan.sv
module sdma_tx_chan
  import sdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ptr,
  input  logic              ld_cnt,
  input  logic [AW-1:0]     ld_val,
  input  logic              en_wr,
  input  logic              en_val,
  input  logic              eob_clr,
  input  logic              src_sel,
  input  logic              cpu_wr,
  input  logic              shf_empty,
  output logic              req,
  input  logic              ack,
  input  logic [BYTE_W-1:0] rdata,
  output logic [AW-1:0]     ptr,
  output logic [CW-1:0]     cnt,
  output logic              en,
  output logic              eob,
  output logic              txb_valid,
  output logic [BYTE_W-1:0] txb_data,
  input  logic              txb_ready,
  output logic              empty_irq
);
  tx_st_e st;
  logic   done, last;

  assign req       = (st == TX_FETCH);
  assign txb_valid = (st == TX_PUSH);
  assign done      = txb_valid && txb_ready;
  assign last      = (cnt == CW'(1));
  assign empty_irq = shf_empty && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      ptr      <= '0;
      cnt      <= '0;
      en       <= 1'b0;
      eob      <= 1'b0;
      txb_data <= '0;
    end else begin
      if (done) begin
        ptr <= ptr + AW'(1);
        cnt <= cnt - CW'(1);
      end else begin
        if (ld_ptr && !en) ptr <= ld_val;
        if (ld_cnt && !en) cnt <= ld_val[CW-1:0];
      end
      if (done && last) en <= 1'b0;
      else if (en_wr)   en <= en_val && (cnt != '0);
      if (done && last) eob <= 1'b1;
      else if (eob_clr) eob <= 1'b0;
      case (st)
        TX_IDLE:  if (en && cpu_wr) st <= TX_WAIT;
        TX_WAIT: begin
          if (!en) st <= TX_IDLE;
          else if (shf_empty && !src_sel) st <= TX_FETCH;
        end
        TX_FETCH: if (ack) begin
          txb_data <= rdata;
          st       <= TX_PUSH;
        end
        TX_PUSH:  if (done) st <= last ? TX_IDLE : TX_WAIT;
        default:  st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdma_arb.sv
module sdma_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_req,
  input  logic tx_req,
  input  logic mem_ack,
  output logic mem_req,
  output logic pick_tx,
  output logic rx_ack,
  output logic tx_ack
);
  logic lock, own_tx;

  assign pick_tx = lock ? own_tx : (tx_req && !rx_req);
  assign mem_req = pick_tx ? tx_req : rx_req;
  assign rx_ack  = mem_ack && mem_req && !pick_tx;
  assign tx_ack  = mem_ack && mem_req && pick_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= 1'b0;
      own_tx <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      lock   <= 1'b1;
      own_tx <= pick_tx;
    end else if (mem_ack) begin
      lock   <= 1'b0;
    end
  end
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_err_line,
  input  logic              rx_err_ovr,
  input  logic              rxbuf_rd,
  input  logic              cpu_txbuf_wr,
  input  logic              tx_empty,
  output logic              txb_valid,
  output logic [BYTE_W-1:0] txb_data,
  input  logic              txb_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              irq_rx_byte,
  output logic              irq_tx_empty,
  output logic              irq_rx_eob,
  output logic              irq_tx_eob,
  output logic              rx_on,
  output logic              tx_on,
  output logic              rx_halt,
  output logic [AW-1:0]     rx_ptr,
  output logic [CW-1:0]     rx_cnt,
  output logic [AW-1:0]     tx_ptr,
  output logic [CW-1:0]     tx_cnt
);
  logic              wr_ctrl, wr_pend;
  logic              src_sel, search_en;
  logic [BYTE_W-1:0] match_char;
  logic              rx_req_w, tx_req_w, rx_ack_w, tx_ack_w, pick_tx;

  assign wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
  assign wr_pend = cfg_wr && (cfg_sel == SEL_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel    <= 1'b0;
      search_en  <= 1'b0;
      match_char <= '0;
    end else begin
      if (wr_ctrl) begin
        src_sel   <= cfg_wdata[CTRL_SRC];
        search_en <= cfg_wdata[CTRL_SEARCH];
      end
      if (cfg_wr && (cfg_sel == SEL_MATCH)) match_char <= cfg_wdata[BYTE_W-1:0];
    end
  end

  sdma_rx_chan #(.AW(AW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .ld_ptr(cfg_wr && (cfg_sel == SEL_RX_PTR)),
    .ld_cnt(cfg_wr && (cfg_sel == SEL_RX_CNT)),
    .ld_val(cfg_wdata),
    .en_wr(wr_ctrl), .en_val(cfg_wdata[CTRL_RX_EN]),
    .eob_clr(wr_pend && cfg_wdata[0]),
    .search_en(search_en), .match_char(match_char),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_line(rx_err_line), .err_ovr(rx_err_ovr), .buf_rd(rxbuf_rd),
    .req(rx_req_w), .wdata(mem_wdata), .ack(rx_ack_w),
    .ptr(rx_ptr), .cnt(rx_cnt), .en(rx_on), .eob(irq_rx_eob),
    .halt(rx_halt), .byte_irq(irq_rx_byte)
  );

  sdma_tx_chan #(.AW(AW), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .ld_ptr(cfg_wr && (cfg_sel == SEL_TX_PTR)),
    .ld_cnt(cfg_wr && (cfg_sel == SEL_TX_CNT)),
    .ld_val(cfg_wdata),
    .en_wr(wr_ctrl), .en_val(cfg_wdata[CTRL_TX_EN]),
    .eob_clr(wr_pend && cfg_wdata[1]),
    .src_sel(src_sel), .cpu_wr(cpu_txbuf_wr), .shf_empty(tx_empty),
    .req(tx_req_w), .ack(tx_ack_w), .rdata(mem_rdata),
    .ptr(tx_ptr), .cnt(tx_cnt), .en(tx_on), .eob(irq_tx_eob),
    .txb_valid(txb_valid), .txb_data(txb_data), .txb_ready(txb_ready),
    .empty_irq(irq_tx_empty)
  );

  sdma_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .rx_req(rx_req_w), .tx_req(tx_req_w), .mem_ack(mem_ack),
    .mem_req(mem_req), .pick_tx(pick_tx),
    .rx_ack(rx_ack_w), .tx_ack(tx_ack_w)
  );

  assign mem_we   = !pick_tx;
  assign mem_addr = pick_tx ? tx_ptr : rx_ptr;
endmodule

// File: rtl/sdma_chk.sv
module sdma_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          txb_valid,
  input logic          txb_ready,
  input logic [7:0]    txb_data,
  input logic          rx_on,
  input logic          rx_halt,
  input logic          rx_ready,
  input logic [CW-1:0] rx_cnt,
  input logic          irq_rx_eob,
  input logic          irq_rx_byte,
  input logic          rx_req_i,
  input logic          tx_req_i
);
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_rx_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req_i && tx_req_i && !($past(mem_req) && !$past(mem_ack)) |-> mem_we);

  p_txb_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    txb_valid && !txb_ready |=> txb_valid && $stable(txb_data));

  p_halt_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_on && rx_halt |-> !rx_ready);

  p_rx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> rx_cnt == $past(rx_cnt) - CW'(1));

  p_eob_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we && rx_cnt == CW'(1) |=> irq_rx_eob && !rx_on);

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_on |-> !irq_rx_byte);
endmodule

bind sdma_ctrl sdma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .txb_valid(txb_valid), .txb_ready(txb_ready), .txb_data(txb_data),
  .rx_on(rx_on), .rx_halt(rx_halt), .rx_ready(rx_ready),
  .rx_cnt(rx_cnt), .irq_rx_eob(irq_rx_eob), .irq_rx_byte(irq_rx_byte),
  .rx_req_i(rx_req_w), .tx_req_i(tx_req_w)
);

// File: tb/tb_sdma_ctrl.sv
`timescale 1ns/1ps
module tb_sdma_ctrl;
  localparam int AW = 8;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0; logic [2:0] cfg_sel = 0; logic [AW-1:0] cfg_wdata = 0;
  logic rx_valid = 0; logic [7:0] rx_data = 0; logic rx_ready;
  logic rx_err_line = 0, rx_err_ovr = 0, rxbuf_rd = 0;
  logic cpu_txbuf_wr = 0, tx_empty = 0;
  logic txb_valid; logic [7:0] txb_data; logic txb_ready = 0;
  logic mem_req, mem_we; logic [AW-1:0] mem_addr; logic [7:0] mem_wdata;
  logic mem_ack = 0; logic [7:0] mem_rdata = 0;
  logic irq_rx_byte, irq_tx_empty, irq_rx_eob, irq_tx_eob, rx_on, tx_on, rx_halt;
  logic [AW-1:0] rx_ptr, tx_ptr; logic [CW-1:0] rx_cnt, tx_cnt;

  always #2 clk = ~clk;

  sdma_ctrl #(.AW(AW), .CW(CW)) dut (.*);

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [7:0] wl_a [64]; logic [7:0] wl_d [64]; int wn = 0;
  logic [7:0] rd_a [64]; int rn = 0;
  logic [7:0] tl [64]; int tn = 0;
  int seq = 0, last_w_seq = 0, last_r_seq = 0;
  int byte_n = 0, empty_n = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] wrap_add(input logic [7:0] a, input int n);
    return 8'(a + n);
  endfunction

  // memory responder with random acknowledge delay
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req && ($urandom % 3 != 0)) begin
        mem_ack = 1;
        seq++;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wl_a[wn] = mem_addr; wl_d[wn] = mem_wdata; wn++;
          last_w_seq = seq;
        end else begin
          mem_rdata = mem[mem_addr];
          rd_a[rn] = mem_addr; rn++;
          last_r_seq = seq;
        end
      end
    end
  end

  // transmit buffer sink with random readiness
  initial begin
    forever begin
      @(negedge clk);
      txb_ready = ($urandom % 2) == 1;
      if (txb_valid && txb_ready) begin
        tl[tn] = txb_data; tn++;
      end
    end
  end

  // per-byte interrupt monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (irq_rx_byte) byte_n++;
      if (irq_tx_empty) empty_n++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic cfg(input logic [2:0] s, input logic [AW-1:0] v);
    @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d);
    do @(negedge clk); while (!rx_ready);
    rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic pulse_empty();
    @(negedge clk); tx_empty = 1;
    @(negedge clk); tx_empty = 0;
  endtask

  initial begin
    logic [7:0] exp_d [8];
    int ne, tgt, w0, r0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(rx_on == 0 && tx_on == 0, "R1 reset enables", {rx_on, tx_on}, 0);
    chk(mem_req == 0, "R10 reset mem_req", mem_req, 0);
    chk(rx_ready == 1, "R12 reset rx_ready", rx_ready, 1);
    chk(irq_rx_eob == 0 && irq_tx_eob == 0, "R3 reset eob", {irq_rx_eob, irq_tx_eob}, 0);

    // R1: enable with zero count ignored
    cfg(3'd3, 0); cfg(3'd4, 8'h02); idle(1);
    chk(tx_on == 0, "R1 zero-count enable", tx_on, 0);

    // R2/R9/R12: receive block with wrap and character search
    cfg(3'd5, 8'h5A);
    cfg(3'd0, 8'hFC); cfg(3'd1, 5); cfg(3'd4, 8'h09);
    idle(1);
    chk(rx_on == 1, "R1 rx enable", rx_on, 1);
    cfg(3'd0, 8'h10); idle(1);
    chk(rx_ptr == 8'hFC, "R1 pointer load while enabled", rx_ptr, 8'hFC);
    ne = 0;
    for (int i = 0; ne < 5; i++) begin
      logic [7:0] d;
      if (i % 3 == 1) d = 8'h5A;
      else begin
        d = 8'($urandom);
        if (d == 8'h5A) d = 8'h11;
        exp_d[ne] = d; ne++;
      end
      send_rx(d);
      if (i == 0) chk(rx_ready == 0, "R12 ready low while holding", rx_ready, 0);
    end
    idle(12);
    chk(wn == 5, "R9 match bytes not written", wn, 5);
    for (int i = 0; i < 5; i++) begin
      chk(wl_a[i] == wrap_add(8'hFC, i), "R2 write address", wl_a[i], wrap_add(8'hFC, i));
      chk(wl_d[i] == exp_d[i], "R2 write data", wl_d[i], exp_d[i]);
    end
    chk(rx_ptr == 8'h01 && rx_cnt == 0, "R2 pointer wrap and count", rx_ptr, 8'h01);
    chk(rx_on == 0 && irq_rx_eob == 1, "R3 rx end of block", {rx_on, irq_rx_eob}, 2'b01);
    chk(byte_n == 0, "R4 rx byte irq suppressed", byte_n, 0);
    cfg(3'd6, 8'h01); idle(1);
    chk(irq_rx_eob == 0, "R3 rx eob write-one-clear", irq_rx_eob, 0);
    send_rx(8'h33); idle(1);
    chk(byte_n == 1 && wn == 5, "R4 rx byte irq when disabled", byte_n, 1);

    // R7: line error halt
    cfg(3'd0, 8'h40); cfg(3'd1, 3); cfg(3'd4, 8'h01);
    @(negedge clk); rx_err_line = 1;
    idle(2);
    chk(rx_halt == 1 && rx_ready == 0, "R7 halt on line error", {rx_halt, rx_ready}, 2'b10);
    rx_err_line = 0; idle(2);
    chk(rx_halt == 0 && rx_ready == 1, "R7 resume after flag clear", {rx_halt, rx_ready}, 2'b01);
    send_rx(8'hA1); idle(6);
    chk(wn == 6 && wl_a[5] == 8'h40, "R7 write after resume", wl_a[5], 8'h40);

    // R8: overrun needs buffer read
    rx_err_ovr = 1; idle(2); rx_err_ovr = 0; idle(3);
    chk(rx_halt == 1 && rx_ready == 0, "R8 still halted without read", rx_halt, 1);
    @(negedge clk); rxbuf_rd = 1; @(negedge clk); rxbuf_rd = 0; idle(1);
    chk(rx_halt == 0, "R8 resume after read", rx_halt, 0);
    send_rx(8'hB2); idle(6);
    chk(wn == 7 && wl_a[6] == 8'h41 && wl_d[6] == 8'hB2, "R8 write after overrun", wl_a[6], 8'h41);
    cfg(3'd4, 8'h00); idle(1);

    // R5/R6/R11: transmit block
    tgt = 2 + ($urandom % 5);
    for (int i = 0; i < tgt; i++) mem[8'h80 + i] = 8'($urandom);
    r0 = rn;
    cfg(3'd2, 8'h80); cfg(3'd3, 8'(tgt)); cfg(3'd4, 8'h02);
    pulse_empty(); idle(4);
    chk(rn == r0, "R5 no fetch before software write", rn, r0);
    chk(empty_n == 0, "R4 empty irq suppressed", empty_n, 0);
    @(negedge clk); cpu_txbuf_wr = 1; @(negedge clk); cpu_txbuf_wr = 0;
    cfg(3'd4, 8'h06);
    pulse_empty(); idle(5);
    chk(rn == r0, "R6 source select blocks fetch", rn, r0);
    cfg(3'd4, 8'h02);
    for (int i = 0; i < tgt; i++) begin
      int lim = 0;
      pulse_empty();
      while (tn != i + 1 && lim < 50) begin @(negedge clk); lim++; end
    end
    idle(2);
    chk(tn == tgt, "R6 one byte per empty event", tn, tgt);
    chk(rd_a[r0] == 8'h80, "R5 first fetch at loaded pointer", rd_a[r0], 8'h80);
    for (int i = 0; i < tgt; i++)
      chk(tl[i] == mem[8'h80 + i], "R11 byte order to buffer", tl[i], mem[8'h80 + i]);
    chk(tx_on == 0 && irq_tx_eob == 1, "R3 tx end of block", {tx_on, irq_tx_eob}, 2'b01);
    chk(tx_ptr == 8'(8'h80 + tgt), "R5 tx pointer advance", tx_ptr, 8'h80 + tgt);
    cfg(3'd6, 8'h02); idle(1);
    chk(irq_tx_eob == 0, "R3 tx eob write-one-clear", irq_tx_eob, 0);
    pulse_empty(); idle(1);
    chk(empty_n == 1, "R4 empty irq when disabled", empty_n, 1);

    // R10: both channels request in the same cycle
    w0 = wn; r0 = rn;
    mem[8'h90] = 8'h77;
    cfg(3'd0, 8'h20); cfg(3'd1, 1); cfg(3'd2, 8'h90); cfg(3'd3, 1); cfg(3'd4, 8'h03);
    @(negedge clk); cpu_txbuf_wr = 1; @(negedge clk); cpu_txbuf_wr = 0;
    @(negedge clk); rx_valid = 1; rx_data = 8'hC3; tx_empty = 1;
    @(negedge clk); rx_valid = 0; tx_empty = 0;
    idle(20);
    chk(wn == w0 + 1 && rn == r0 + 1, "R10 both transfers done", wn - w0, 1);
    chk(last_w_seq < last_r_seq, "R10 receive served first", last_w_seq, last_r_seq);
    chk(wl_a[w0] == 8'h20 && rd_a[r0] == 8'h90, "R10 addresses", wl_a[w0], 8'h20);
    chk(tl[tn-1] == 8'h77, "R11 collided fetch data", tl[tn-1], 8'h77);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule